// File: doc/BRIEF.md
# Multi-Channel Threshold Watchdog

The block watches a stream of signed conversion samples, each arriving with a channel number and a one-cycle valid strobe. Every accepted sample is compared against a programmable upper limit and a programmable lower limit. A sample beyond either limit sets a sticky flag for its channel. Upper and lower crossings are kept in two separate per-channel flag vectors.

A source-select input picks the value that is compared. It is either the final output data or a separate fast-filter data word that comes with the same strobe. A per-channel watch mask decides which channels take part. A channel whose mask bit is clear never changes its flags.

Software clears each flag bit on its own with a write-one pulse. A summary flag is the OR of all flag bits, and an interrupt request follows the summary flag while the interrupt enable is set. The filters that produce the samples sit outside the block.

Top module: `mcw_watchdog`

## Requirements
- R1: An accepted sample whose compared value is strictly greater than `thr_hi` (both read as signed 24-bit) sets `hi_flags[smp_chan]` at the next rising clock edge.
- R2: An accepted sample whose compared value is strictly less than `thr_lo` (signed 24-bit) sets `lo_flags[smp_chan]` at the next rising clock edge.
- R3: A compared value equal to `thr_hi` or to `thr_lo` sets no flag.
- R4: With `src_sel` = 0 the compared value is `out_data`. With `src_sel` = 1 it is `fast_data`. The value that is not selected has no effect.
- R5: A sample on a channel whose `chan_mask` bit is 0 changes no flag.
- R6: A sample is only evaluated in a cycle where `smp_valid` is 1. While it is 0, no flag is set.
- R7: A set flag stays set until its clear bit is pulsed. A 1 on `clr_hi[i]` or `clr_lo[i]` clears only that bit at the next edge.
- R8: If a new crossing and a clear reach the same flag bit in the same cycle, the bit stays set.
- R9: `any_flag` is the OR of all bits of `hi_flags` and `lo_flags`. `irq` equals `any_flag` AND `irq_en`. Both follow without a register delay.
- R10: While `rst_n` is 0, all flags, `any_flag` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 3 | Channel number of the sample |
| out_data | input | 24 | Final output data, signed |
| fast_data | input | 24 | Fast-filter data, signed |
| src_sel | input | 1 | 0 compares out_data, 1 compares fast_data |
| chan_mask | input | 8 | Per-channel watch enable |
| thr_hi | input | 24 | Upper limit, signed |
| thr_lo | input | 24 | Lower limit, signed |
| irq_en | input | 1 | Interrupt enable |
| clr_hi | input | 8 | Write-one clear pulses for hi_flags |
| clr_lo | input | 8 | Write-one clear pulses for lo_flags |
| hi_flags | output | 8 | Sticky upper-crossing flags |
| lo_flags | output | 8 | Sticky lower-crossing flags |
| any_flag | output | 1 | OR of all flags |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a crossing and a clear landing on the same flag bit in the same cycle, together with an exact-equality sample on a watched channel. Random traffic almost never produces either by chance. Directed steps force both. The random phase keeps samples in a narrow band around the limits and gates clear pulses so that they are sparse. This makes collisions between sets and clears, and samples that land at or near a limit, occur many times. A bench model predicts every flag bit on every cycle.

// File: rtl/mcw_pkg.sv
package mcw_pkg;
   // source select encoding
   typedef enum logic {
      SRC_OUT  = 1'b0,
      SRC_FAST = 1'b1
   } src_e;

   // verdict of one comparison
   typedef struct packed {
      logic above;
      logic below;
   } verdict_t;
endpackage

// File: rtl/mcw_src_select.sv
module mcw_src_select #(
   parameter int DATA_W   = 24,
   parameter bit HAS_FAST = 1'b1
) (
   input  logic                     src_sel,
   input  logic signed [DATA_W-1:0] out_data,
   input  logic signed [DATA_W-1:0] fast_data,
   output logic signed [DATA_W-1:0] cmp_val
);
   import mcw_pkg::*;

   generate
      if (HAS_FAST) begin : g_two_src
         always_comb begin
            if (src_e'(src_sel) == SRC_FAST) cmp_val = fast_data;
            else                             cmp_val = out_data;
         end
      end else begin : g_one_src
         logic unused_in;
         assign unused_in = src_sel ^ (^fast_data);
         assign cmp_val   = out_data;
      end
   endgenerate
endmodule

// File: rtl/mcw_compare.sv
module mcw_compare #(
   parameter int DATA_W = 24,
   parameter int CH_W   = 3,
   parameter bit PIPE   = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     valid_i,
   input  logic [CH_W-1:0]          chan_i,
   input  logic signed [DATA_W-1:0] val_i,
   input  logic signed [DATA_W-1:0] thr_hi_i,
   input  logic signed [DATA_W-1:0] thr_lo_i,
   output logic                     valid_o,
   output logic [CH_W-1:0]          chan_o,
   output mcw_pkg::verdict_t        verdict_o
);
   import mcw_pkg::*;

   verdict_t v_now;

   always_comb begin
      v_now.above = (val_i > thr_hi_i);
      v_now.below = (val_i < thr_lo_i);
   end

   generate
      if (PIPE) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_o   <= 1'b0;
               chan_o    <= '0;
               verdict_o <= '0;
            end else begin
               valid_o   <= valid_i;
               chan_o    <= chan_i;
               verdict_o <= v_now;
            end
         end
      end else begin : g_comb
         assign valid_o   = valid_i;
         assign chan_o    = chan_i;
         assign verdict_o = v_now;

         // R3
         eq_hi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (val_i == thr_hi_i) |-> !verdict_o.above);
         // R3
         eq_lo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (val_i == thr_lo_i) |-> !verdict_o.below);
      end
   endgenerate
endmodule

// File: rtl/mcw_flag_bank.sv
module mcw_flag_bank #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_i,
   input  logic [NUM_CH-1:0] clr_i,
   output logic [NUM_CH-1:0] flag_o
);
   genvar i;
   generate
      for (i = 0; i < NUM_CH; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (clr_i[i]) flag_o[i] <= 1'b0;
         end

         // R7
         sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
         // R7
         clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
         // R8
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_o[i]);
         // R1
         rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !flag_o[i] && !set_i[i] |=> !flag_o[i]);
      end
   endgenerate
endmodule

// File: rtl/mcw_watchdog.sv
module mcw_watchdog #(
   parameter int DATA_W   = 24,
   parameter int NUM_CH   = 8,
   parameter bit HAS_FAST = 1'b1,
   parameter bit PIPE     = 1'b0,
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_valid,
   input  logic [CH_W-1:0]          smp_chan,
   input  logic signed [DATA_W-1:0] out_data,
   input  logic signed [DATA_W-1:0] fast_data,
   input  logic                     src_sel,
   input  logic [NUM_CH-1:0]        chan_mask,
   input  logic signed [DATA_W-1:0] thr_hi,
   input  logic signed [DATA_W-1:0] thr_lo,
   input  logic                     irq_en,
   input  logic [NUM_CH-1:0]        clr_hi,
   input  logic [NUM_CH-1:0]        clr_lo,
   output logic [NUM_CH-1:0]        hi_flags,
   output logic [NUM_CH-1:0]        lo_flags,
   output logic                     any_flag,
   output logic                     irq
);
   import mcw_pkg::*;

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("mcw_watchdog: DATA_W must be at least 2");
      end
      if (NUM_CH < 2 || NUM_CH > 64) begin : g_bad_ch
         $error("mcw_watchdog: NUM_CH must be in 2..64");
      end
   endgenerate

   logic signed [DATA_W-1:0] cmp_val;
   logic                     cmp_valid;
   logic [CH_W-1:0]          cmp_chan;
   verdict_t                 verdict;
   logic [NUM_CH-1:0]        set_hi, set_lo;

   mcw_src_select #(.DATA_W(DATA_W), .HAS_FAST(HAS_FAST)) i_sel (
      .src_sel  (src_sel),
      .out_data (out_data),
      .fast_data(fast_data),
      .cmp_val  (cmp_val)
   );

   mcw_compare #(.DATA_W(DATA_W), .CH_W(CH_W), .PIPE(PIPE)) i_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (smp_valid),
      .chan_i   (smp_chan),
      .val_i    (cmp_val),
      .thr_hi_i (thr_hi),
      .thr_lo_i (thr_lo),
      .valid_o  (cmp_valid),
      .chan_o   (cmp_chan),
      .verdict_o(verdict)
   );

   // channel decode, gated by strobe and watch mask
   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_dec
         logic hit;
         assign hit       = cmp_valid && (cmp_chan == CH_W'(c)) && chan_mask[c];
         assign set_hi[c] = hit && verdict.above;
         assign set_lo[c] = hit && verdict.below;
      end
   endgenerate

   mcw_flag_bank #(.NUM_CH(NUM_CH)) i_hi_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_hi),
      .clr_i (clr_hi),
      .flag_o(hi_flags)
   );

   mcw_flag_bank #(.NUM_CH(NUM_CH)) i_lo_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_lo),
      .clr_i (clr_lo),
      .flag_o(lo_flags)
   );

   assign any_flag = (|hi_flags) | (|lo_flags);
   assign irq      = any_flag & irq_en;

   // R5
   mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !chan_mask[cmp_chan] && !hi_flags[cmp_chan] && !lo_flags[cmp_chan])
      |=> !hi_flags[$past(cmp_chan)] && !lo_flags[$past(cmp_chan)]);
   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_valid && hi_flags == '0 && lo_flags == '0) |=> (hi_flags == '0 && lo_flags == '0));
   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_en && (hi_flags != '0 || lo_flags != '0)));
   // R10
   always_comb begin
      if (!rst_n) begin
         reset_clear_chk: assert (hi_flags == '0 && lo_flags == '0);
      end
   end
endmodule

// File: tb/test_mcw_watchdog.sv
module test_mcw_watchdog;
   localparam int W  = 24;
   localparam int NC = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic [2:0] smp_chan = '0;
   logic signed [W-1:0] out_data = '0, fast_data = '0, thr_hi = '0, thr_lo = '0;
   logic src_sel = 1'b0, irq_en = 1'b0;
   logic [NC-1:0] chan_mask = '0, clr_hi = '0, clr_lo = '0;
   logic [NC-1:0] hi_flags, lo_flags;
   logic any_flag, irq;

   logic [NC-1:0] exp_hi = '0, exp_lo = '0;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mcw_watchdog i_mcw_watchdog (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
      .out_data(out_data), .fast_data(fast_data), .src_sel(src_sel),
      .chan_mask(chan_mask), .thr_hi(thr_hi), .thr_lo(thr_lo), .irq_en(irq_en),
      .clr_hi(clr_hi), .clr_lo(clr_lo), .hi_flags(hi_flags), .lo_flags(lo_flags),
      .any_flag(any_flag), .irq(irq)
   );

   function automatic logic signed [W-1:0] pick();
      return src_sel ? fast_data : out_data;
   endfunction

   // model of the flag update at one rising edge
   task automatic model_edge();
      logic [NC-1:0] nh, nl;
      nh = '0; nl = '0;
      if (smp_valid && chan_mask[smp_chan]) begin
         if (pick() > thr_hi) nh[smp_chan] = 1'b1;
         if (pick() < thr_lo) nl[smp_chan] = 1'b1;
      end
      exp_hi = (exp_hi & ~clr_hi) | nh;
      exp_lo = (exp_lo & ~clr_lo) | nl;
   endtask

   task automatic check_all(input string req);
      logic [17:0] act, expv;
      logic ea;
      ea   = (|exp_hi) | (|exp_lo);
      act  = {hi_flags, lo_flags, any_flag, irq};
      expv = {exp_hi, exp_lo, ea, ea & irq_en};
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic tick(input string req);
      @(posedge clk);
      model_edge();
      #2;
      check_all(req);
   endtask

   task automatic quiet();
      smp_valid = 1'b0; clr_hi = '0; clr_lo = '0;
   endtask

   task automatic sample(input int ch, input int ov, input int fv);
      smp_valid = 1'b1; smp_chan = 3'(ch);
      out_data = W'(ov); fast_data = W'(fv);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      thr_hi = 24'sd100; thr_lo = -24'sd100; chan_mask = '1; irq_en = 1'b1;
      sample(2, 500, 0);
      repeat (3) @(posedge clk);
      #2;
      // R10: reset state despite active inputs
      checks++;
      if ({hi_flags, lo_flags, any_flag, irq} !== 18'h0) begin
         fails++;
         $display("FAIL R10: actual %h expected 0", {hi_flags, lo_flags, any_flag, irq});
      end
      quiet();
      rst_n = 1'b1;
      tick("R10");

      // R1: above high threshold
      sample(3, 101, 0); tick("R1");
      // R9: summary and interrupt
      quiet(); tick("R9");
      irq_en = 1'b0; #1; check_all("R9 irq_en off");
      irq_en = 1'b1;
      // R2: below low, negative signed
      sample(5, -101, 0); tick("R2");
      // R3: equal to thresholds
      sample(0, 100, 0); tick("R3 hi");
      sample(1, -100, 0); tick("R3 lo");
      // R4: fast source
      src_sel = 1'b1; sample(6, 0, 9000); tick("R4 fast");
      sample(7, 9000, 0); tick("R4 out ignored");
      src_sel = 1'b0;
      // R5: masked channel
      chan_mask = 8'b1111_1011; sample(2, 5000, 0); tick("R5");
      chan_mask = '1;
      // R6: strobe low
      quiet(); smp_chan = 3'd4; out_data = 24'sd7000; tick("R6");
      // R7: single-bit clear
      clr_hi = 8'b0000_1000; tick("R7");
      quiet(); tick("R7 hold");
      // R8: set and clear together
      sample(6, 0, 0); src_sel = 1'b1; fast_data = 24'sd400; clr_hi = 8'b0100_0000;
      tick("R8");
      quiet(); src_sel = 1'b0;
      clr_hi = '1; clr_lo = '1; tick("R7 clear all");
      quiet(); tick("R9 idle");

      // random phase
      for (int n = 0; n < 3000; n++) begin
         smp_valid = ($urandom_range(3) != 0);
         smp_chan  = 3'($urandom_range(7));
         out_data  = W'($urandom_range(600)) - 24'sd300;
         fast_data = W'($urandom_range(600)) - 24'sd300;
         src_sel   = 1'($urandom_range(1));
         if ($urandom_range(15) == 0) chan_mask = 8'($urandom);
         if ($urandom_range(31) == 0) begin
            thr_hi = W'($urandom_range(200)) - 24'sd50;
            thr_lo = W'($urandom_range(200)) - 24'sd150;
         end
         if ($urandom_range(7) == 0) irq_en = ~irq_en;
         clr_hi = 8'($urandom & $urandom & $urandom);
         clr_lo = 8'($urandom & $urandom & $urandom);
         if ($urandom_range(9) == 0) out_data = thr_hi;
         tick("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule